// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Programmable Divisor

This block is a full-duplex asynchronous serial port core. One shared rate generator divides the system clock into a 16x oversampling tick. The tick period is set by a 16-bit divisor input that holds the wanted clock count minus one. The transmitter takes parallel bytes and turns them into serial frames. The receiver finds start bits on the incoming line, samples each bit near its middle, and returns the recovered byte. Each returned byte carries its own parity, framing and overrun flags.

The character format comes from a configuration byte:

| Bit | Meaning when set | Meaning when clear |
|-----|------------------|--------------------|
| 0 | 8 data bits | 7 data bits |
| 1 | two stop bits | one stop bit |
| 2 | parity bit present | no parity bit |
| 4 | odd parity | even parity |

All other configuration bits are ignored.

Both data paths use valid/ready handshakes:

- **Transmit side.** A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low until the whole frame, including its last stop bit, has left the shifter. The producer may hold `tx_valid` high and wait.
- **Receive side.** `rx_valid` rises with a new result. The result stays frozen until a clock edge where `rx_ready` is high. The receiver cannot be stalled by the line. If a new frame completes while the previous result is still unconsumed, the new result replaces the old one and is marked as an overrun.

Top module: `serial_xcvr`

## Requirements
- R1: While and after reset, `txd` is high, `tx_ready` and `tx_idle` are high, and `rx_valid` is low.
- R2: Every serial bit lasts exactly 16 ticks. A tick occurs once every `baud_div`+1 clocks, so the baud rate is clk/(16*(`baud_div`+1)).
- R3: A transmitted frame begins with one low start bit. The data bits follow LSB first: 8 of them when `frame_cfg[0]`=1, or 7 (bits 6..0) when it is 0.
- R4: When `frame_cfg[2]`=1, a parity bit follows the data bits. With `frame_cfg[4]`=0 it makes the count of ones over data plus parity even; with `frame_cfg[4]`=1 it makes that count odd.
- R5: The frame ends with one high stop bit, or two when `frame_cfg[1]`=1.
- R6: A byte is accepted on an edge where `tx_valid` and `tx_ready` are both high. `tx_ready` and `tx_idle` are low from the next cycle until the cycle after the last stop bit ends.
- R7: The receiver treats a low line seen at a tick as a candidate start bit and samples again 8 ticks later. If the line is high then, the candidate is dropped and no result is produced.
- R8: Received data bits are sampled every 16 ticks after the start confirmation and assembled LSB first. In 7-bit mode `rx_data[7]` is 0.
- R9: `rx_par_err` is 1 when parity is enabled and the received parity bit does not match the configured sense. It is always 0 with parity disabled.
- R10: `rx_frm_err` is 1 when the first stop bit samples low.
- R11: When a frame completes while `rx_valid` is high and `rx_ready` is low, the new byte replaces the held one and `rx_ovr_err` is 1.
- R12: While `rx_valid` is high and `rx_ready` is low, the result is held unchanged. An edge with `rx_ready` high consumes the result, and `rx_valid` then drops unless a new frame completes on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_cfg | input | 8 | Character format (bit 0 length, 1 stop count, 2 parity enable, 4 odd parity) |
| baud_div | input | 16 | Clocks per oversampling tick minus one |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_idle | output | 1 | Transmit shifter empty, line idle |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line (asynchronous) |
| rx_data | output | 8 | Received byte |
| rx_par_err | output | 1 | Parity mismatch on `rx_data` |
| rx_frm_err | output | 1 | First stop bit was low |
| rx_ovr_err | output | 1 | Previous result was overwritten |
| rx_valid | output | 1 | Receive result is available |
| rx_ready | input | 1 | Consumer takes the result |

## Verification
The embedded properties assume the following:

- `frame_cfg` does not change while a frame is in flight.
- Any change of `baud_div` is visible only as a change in tick spacing.
- `rxd` frames arrive at the same bit period the divisor sets.

The stimulus changes format and divisor only while both directions are idle. It drives every receive frame, including the deliberately broken ones (flipped parity, shortened low stop bit, short glitch), with a period of exactly 16*(`baud_div`+1) clocks per bit. A behavioural model of the transmit line, built from bit queues and an integer tick counter, is compared with `txd`, `tx_ready` and `tx_idle` on every clock.

// File: rtl/serial_xcvr_pkg.sv
package serial_xcvr_pkg;

  localparam int OSR   = 16;
  localparam int OSR_W = $clog2(OSR);

  // configuration bit positions (decoded by the top level)
  localparam int CFG_EIGHT    = 0;
  localparam int CFG_TWO_STOP = 1;
  localparam int CFG_PAR_EN   = 2;
  localparam int CFG_PAR_ODD  = 4;

  typedef struct packed {
    logic eight;
    logic two_stop;
    logic par_en;
    logic par_odd;
  } frame_fmt_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

endpackage

// File: rtl/sx_tick_gen.sv
module sx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || !$stable(div))); // R2

endmodule

// File: rtl/sx_tx.sv
module sx_tx
  import serial_xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  frame_fmt_t        fmt,
  input  logic [DATA_W-1:0] data,
  input  logic              valid,
  output logic              ready,
  output logic              idle,
  output logic              txd
);

  localparam int FRAME_MAX = DATA_W + 4;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  logic [FRAME_MAX-1:0] frame_next, shreg;
  logic [LEN_W-1:0]     len_next, left;
  logic [OSR_W-1:0]     tcnt;
  logic                 busy, par_bit;

  always_comb begin
    frame_next    = '1;
    frame_next[0] = 1'b0;
    par_bit       = fmt.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (fmt.eight || i < DATA_W - 1) begin
        frame_next[i+1] = data[i];
        par_bit         = par_bit ^ data[i];
      end
    end
    if (fmt.par_en) begin
      if (fmt.eight) frame_next[DATA_W+1] = par_bit;
      else           frame_next[DATA_W]   = par_bit;
    end
    len_next = LEN_W'(2 + (fmt.eight ? DATA_W : DATA_W - 1)
                      + (fmt.par_en ? 1 : 0) + (fmt.two_stop ? 1 : 0));
  end

  assign ready = !busy;
  assign idle  = !busy;
  assign txd   = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
      tcnt  <= '0;
    end else if (!busy) begin
      if (valid) begin
        shreg <= frame_next;
        left  <= len_next;
        tcnt  <= '0;
        busy  <= 1'b1;
      end
    end else if (tick) begin
      if (tcnt == OSR_W'(OSR - 1)) begin
        tcnt  <= '0;
        shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
        left  <= left - 1'b1;
        if (left == LEN_W'(1)) busy <= 1'b0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> !txd); // R3
  AST_TX_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> !ready); // R6
  AST_TX_BIT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !tick) |=> $stable(txd)); // R2
  AST_TX_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(txd)); // R5

endmodule

// File: rtl/sx_rx.sv
module sx_rx
  import serial_xcvr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  frame_fmt_t        fmt,
  input  logic              rxd,
  output logic [DATA_W-1:0] data,
  output logic              par_err,
  output logic              frm_err,
  output logic              ovr_err,
  output logic              valid,
  input  logic              ready
);

  localparam int BC_W = $clog2(DATA_W);

  logic [SYNC_STAGES-1:0] sync;
  logic                   rx_s, mid, deliver, par_acc, fmt_unused;
  logic [OSR_W-1:0]       tcnt;
  logic [BC_W-1:0]        bcnt, last_bit;
  logic [DATA_W-1:0]      shreg;
  rx_state_t              state;

  assign fmt_unused = fmt.two_stop;
  assign rx_s       = sync[SYNC_STAGES-1];
  assign mid        = tick && (tcnt == OSR_W'(OSR - 1));
  assign deliver    = (state == RX_STOP) && mid;
  assign last_bit   = fmt.eight ? BC_W'(DATA_W - 1) : BC_W'(DATA_W - 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '1;
    else        sync <= {sync[SYNC_STAGES-2:0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      tcnt    <= '0;
      bcnt    <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
    end else begin
      case (state)
        RX_IDLE: if (tick && !rx_s) begin
          state   <= RX_START;
          tcnt    <= '0;
          bcnt    <= '0;
          par_acc <= 1'b0;
        end
        RX_START: if (tick) begin
          if (tcnt == OSR_W'(OSR / 2 - 1)) begin
            tcnt  <= '0;
            state <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (mid) begin
            tcnt    <= '0;
            shreg   <= {rx_s, shreg[DATA_W-1:1]};
            par_acc <= par_acc ^ rx_s;
            bcnt    <= bcnt + 1'b1;
            if (bcnt == last_bit) state <= fmt.par_en ? RX_PAR : RX_STOP;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_PAR: if (tick) begin
          if (mid) begin
            tcnt    <= '0;
            par_acc <= par_acc ^ rx_s;
            state   <= RX_STOP;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (mid) begin
            tcnt  <= '0;
            state <= RX_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      data    <= '0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
      ovr_err <= 1'b0;
    end else if (deliver) begin
      valid   <= 1'b1;
      data    <= fmt.eight ? shreg : (shreg >> 1);
      par_err <= fmt.par_en && (par_acc != fmt.par_odd);
      frm_err <= !rx_s;
      ovr_err <= valid && !ready;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  AST_RX_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && tick && tcnt == OSR_W'(OSR / 2 - 1) && rx_s)
      |=> (state == RX_IDLE)); // R7
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !deliver) |=> (valid && $stable(data))); // R12
  AST_RX_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !deliver) |=> !valid); // R12
  AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && valid && !ready) |=> (valid && ovr_err)); // R11

endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
  import serial_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        frame_cfg,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_idle,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_par_err,
  output logic              rx_frm_err,
  output logic              rx_ovr_err,
  output logic              rx_valid,
  input  logic              rx_ready
);

  frame_fmt_t fmt;
  logic       tick;
  logic       cfg_unused;

  assign fmt.eight    = frame_cfg[CFG_EIGHT];
  assign fmt.two_stop = frame_cfg[CFG_TWO_STOP];
  assign fmt.par_en   = frame_cfg[CFG_PAR_EN];
  assign fmt.par_odd  = frame_cfg[CFG_PAR_ODD];
  assign cfg_unused   = ^{frame_cfg[7:5], frame_cfg[3]};

  sx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  sx_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt),
    .data(tx_data), .valid(tx_valid), .ready(tx_ready),
    .idle(tx_idle), .txd(txd)
  );

  sx_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt), .rxd(rxd),
    .data(rx_data), .par_err(rx_par_err), .frm_err(rx_frm_err),
    .ovr_err(rx_ovr_err), .valid(rx_valid), .ready(rx_ready)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (txd && tx_ready && !rx_valid)); // R1

endmodule

// File: tb/serial_xcvr_test.sv
module serial_xcvr_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  frame_cfg = 8'h01;
  logic [15:0] baud_div = 16'd1;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_valid = 1'b0;
  logic        tx_ready, tx_idle, txd;
  logic        rxd = 1'b1;
  logic [7:0]  rx_data;
  logic        rx_par_err, rx_frm_err, rx_ovr_err, rx_valid;
  logic        rx_ready = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_xcvr uut (
    .clk(clk), .rst_n(rst_n), .frame_cfg(frame_cfg), .baud_div(baud_div),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_idle(tx_idle), .txd(txd), .rxd(rxd), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
    .rx_ovr_err(rx_ovr_err), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  typedef bit bitq_t[$];

  function automatic bitq_t frame_bits(input logic [7:0] d, input logic [7:0] c);
    bitq_t q;
    bit    p;
    int    nb;
    nb = c[0] ? 8 : 7;
    p  = c[4];
    q.push_back(1'b0);
    for (int i = 0; i < nb; i++) begin
      q.push_back(d[i]);
      p = p ^ d[i];
    end
    if (c[2]) q.push_back(p);
    q.push_back(1'b1);
    if (c[1]) q.push_back(1'b1);
    return q;
  endfunction

  // behavioural transmit-line model
  int    tcnt_m = 0;
  int    tb_m   = 0;
  bit    busy_m = 1'b0;
  bitq_t txq;

  always @(posedge clk) begin
    bit tick_m;
    if (!rst_n) begin
      tcnt_m = 0;
      tb_m   = 0;
      busy_m = 1'b0;
      txq.delete();
    end else begin
      tick_m = (tcnt_m >= int'(baud_div));
      tcnt_m = tick_m ? 0 : tcnt_m + 1;
      if (busy_m) begin
        if (tick_m) begin
          tb_m++;
          if (tb_m == 16) begin
            tb_m = 0;
            void'(txq.pop_front());
            if (txq.size() == 0) busy_m = 1'b0;
          end
        end
      end else if (tx_valid) begin
        txq    = frame_bits(tx_data, frame_cfg);
        busy_m = 1'b1;
        tb_m   = 0;
      end
    end
  end

  always @(negedge clk) begin
    bit exp_txd;
    if (rst_n) begin
      exp_txd = busy_m ? txq[0] : 1'b1;
      check(txd == exp_txd, "R2 R3 R4 R5", "txd", int'(txd), int'(exp_txd));
      check(tx_ready == !busy_m, "R6", "tx_ready", int'(tx_ready), int'(!busy_m));
      check(tx_idle == !busy_m, "R6", "tx_idle", int'(tx_idle), int'(!busy_m));
    end
  end

  function automatic int bit_clks();
    return 16 * (int'(baud_div) + 1);
  endfunction

  task automatic send_tx(input logic [7:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_tx_idle();
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic drive_rx(input bitq_t q);
    foreach (q[i]) begin
      rxd = q[i];
      repeat (bit_clks()) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  task automatic expect_rx(input logic [7:0] d, input bit pe, input bit fe,
                           input bit oe, input string req);
    check(rx_valid == 1'b1, req, "rx_valid", int'(rx_valid), 1);
    check(rx_data == d, req, "rx_data", int'(rx_data), int'(d));
    check(rx_par_err == pe, "R9", "rx_par_err", int'(rx_par_err), int'(pe));
    check(rx_frm_err == fe, "R10", "rx_frm_err", int'(rx_frm_err), int'(fe));
    check(rx_ovr_err == oe, "R11", "rx_ovr_err", int'(rx_ovr_err), int'(oe));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check(rx_valid == 1'b0, "R12", "rx_valid after consume", int'(rx_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired (R1..) actual=hung expected=done");
    summary();
  end

  initial begin
    bitq_t q;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
    check(tx_ready == 1'b1, "R1", "tx_ready in reset", int'(tx_ready), 1);
    check(rx_valid == 1'b0, "R1", "rx_valid in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_idle == 1'b1, "R1", "tx_idle after reset", int'(tx_idle), 1);

    // 8N1, divisor 1: back-to-back transmit and a clean receive (R3 R8)
    frame_cfg = 8'h01; baud_div = 16'd1;
    send_tx(8'hA5);
    send_tx(8'h3C);
    wait_tx_idle();
    drive_rx(frame_bits(8'hA5, frame_cfg));
    expect_rx(8'hA5, 0, 0, 0, "R8");

    // 7E1, divisor 0 (R4 R8: MSB zero in 7-bit mode)
    frame_cfg = 8'h04; baud_div = 16'd0;
    send_tx(8'h5B);
    wait_tx_idle();
    drive_rx(frame_bits(8'hCD, frame_cfg));
    expect_rx(8'h4D, 0, 0, 0, "R8");

    // 8O2, divisor 3 (R4 R5)
    frame_cfg = 8'h17; baud_div = 16'd3;
    send_tx(8'h81);
    wait_tx_idle();
    drive_rx(frame_bits(8'h81, frame_cfg));
    expect_rx(8'h81, 0, 0, 0, "R5");

    // R9: parity error, 8E1
    frame_cfg = 8'h05; baud_div = 16'd1;
    q = frame_bits(8'h96, frame_cfg);
    q[9] = ~q[9];
    drive_rx(q);
    expect_rx(8'h96, 1, 0, 0, "R9");

    // R10: first stop bit low, shortened so the line returns high
    frame_cfg = 8'h01;
    q = frame_bits(8'h33, frame_cfg);
    for (int i = 0; i < 9; i++) begin
      rxd = q[i];
      repeat (bit_clks()) @(negedge clk);
    end
    rxd = 1'b0;
    repeat (12 * (int'(baud_div) + 1)) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bit_clks()) @(negedge clk);
    expect_rx(8'h33, 0, 1, 0, "R10");

    // R7: short low glitch is rejected, then a good frame is received
    rxd = 1'b0;
    repeat (3 * (int'(baud_div) + 1)) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bit_clks()) @(negedge clk);
    check(rx_valid == 1'b0, "R7", "rx_valid after glitch", int'(rx_valid), 0);
    drive_rx(frame_bits(8'h5A, frame_cfg));
    expect_rx(8'h5A, 0, 0, 0, "R7");

    // R11 R12: overrun replaces the held byte
    drive_rx(frame_bits(8'h11, frame_cfg));
    check(rx_valid == 1'b1, "R12", "first byte held", int'(rx_valid), 1);
    check(rx_data == 8'h11, "R12", "held data", int'(rx_data), 8'h11);
    drive_rx(q[0:0]);
    check(rx_data == 8'h11, "R12", "held data during next frame", int'(rx_data), 8'h11);
    q = frame_bits(8'h22, frame_cfg);
    drive_rx(q[1:$]);
    expect_rx(8'h22, 0, 0, 1, "R11");

    repeat (20) @(negedge clk);
    summary();
  end

endmodule